// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Watermark Flags

This block is a single-clock first-in first-out buffer. Words enter through a write port and leave through a registered read port, and each port is gated by its own enable. Besides the usual empty and full indications, it drives two watermark flags. Each watermark flag compares occupancy against a threshold held in an offset register. Software or a neighbouring block loads the two thresholds one bit at a time through a serial input that has its own enable. The same thresholds can be read back through the read port by pulling the load-select input low while reading.

Two commands change the read position without touching the stored data. A partial clear empties the buffer and zeroes the output register, and it keeps the thresholds and the flag timing mode. A rewind moves the read position back to zero, or to a position recorded earlier by a mark command, so that data already read can be replayed. A mode input, taken at master reset, chooses how the watermark flags are timed. They either follow occupancy in the same cycle or come from a register that lags by one clock.

Top module: `sync_fifo_pflags`

## Requirements
- R1: While `rstN` is low at a clock edge (synchronous master reset), the buffer becomes empty (`isEmpty`=1, `isFull`=0), `rdData` becomes 0, the mark is forgotten, the low offset becomes LOW_DEF and the high offset becomes HIGH_DEF.
- R2: A read happens at an edge where `rdEn`=1, `loadSel`=1 and the buffer is not empty. The oldest word appears on `rdData` after that edge, and words come out in write order.
- R3: A write (`wrEn`=1) while full, with no read in the same cycle, is dropped and leaves the contents unchanged. A read while empty is dropped, and `rdData` keeps its value.
- R4: A read and a write in the same cycle leave occupancy unchanged. This also holds when the buffer is full, and the word read is the oldest one.
- R5: `isEmpty` is 1 exactly when occupancy is 0. `isFull` is 1 exactly when occupancy equals DEPTH.
- R6: `aboveLowMark` is 1 when occupancy is greater than or equal to the low offset, and 0 when it is below.
- R7: `belowHighMark` is 1 when the number of free locations is greater than the high offset, and 0 when it is less than or equal to it.
- R8: At each edge with `serEn`=1, `serBit` shifts into a 2*(log2(DEPTH)+1)-bit offset chain. After a full load, the first bit shifted in is bit 0 of the low offset, and the last bit shifted in is the top bit of the high offset. Both offsets are sent LSB first, the low offset before the high offset.
- R9: A read with `loadSel`=0 leaves the pointers alone. It loads `rdData` with an offset, zero-extended, alternating between the low offset (first) and the high offset. The alternation restarts with the low offset after a master reset or a partial clear.
- R10: `clearIn`=1 at an edge sets occupancy and both positions to zero, zeroes `rdData`, forgets the mark and restarts the readback alternation. It keeps both offsets and the flag mode. It overrides any read, write, mark or rewind in the same cycle.
- R11: `markIn`=1 at an edge records the read position as it was before that edge's read.
- R12: `rewindIn`=1 at an edge moves the read position to the recorded mark, or to 0 if no mark is recorded. Occupancy becomes (write position − new read position) mod DEPTH. Reads, writes and marks in that cycle are ignored.
- R13: `flagModeIn` is taken at master reset. With 0, the watermark flags follow R6/R7 in the same cycle as occupancy. With 1, each flag shows the value R6/R7 gave for the state before the previous edge. The registered flags read 0 (`aboveLowMark`) and 1 (`belowHighMark`) right after master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous master reset, active low |
| clearIn | input | 1 | Partial clear, keeps the configuration |
| flagModeIn | input | 1 | Flag timing mode, taken at master reset (1 = registered) |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read enable |
| loadSel | input | 1 | 1 = read FIFO data, 0 = read back offsets |
| rdData | output | DATA_W | Registered read data |
| serEn | input | 1 | Serial offset shift enable |
| serBit | input | 1 | Serial offset data bit |
| markIn | input | 1 | Record the current read position |
| rewindIn | input | 1 | Move the read position to the mark or to zero |
| isEmpty | output | 1 | Occupancy is zero |
| isFull | output | 1 | Occupancy equals DEPTH |
| aboveLowMark | output | 1 | Occupancy at or above the low offset |
| belowHighMark | output | 1 | Free space above the high offset |

## Verification
The bench builds the block with DEPTH=8 and DATA_W=8, so each offset is 4 bits and the serial chain is 8 bits long. With this size the buffer fills after eight writes, and random traffic reaches full, empty and pointer wrap many times. An 8-bit data word still holds a zero-extended offset on readback. With the small offsets, the thresholds can be placed so that both watermark flags toggle often. The bench runs random traffic in both flag timing modes, and rewinds in that traffic often hit the case where occupancy is recomputed modulo DEPTH.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Per-cycle strobes sent from control to datapath
  typedef struct packed {
    logic push;     // store wrData at wrAddr
    logic pop;      // load rdData from rdAddr
    logic offRead;  // load rdData with an offset value
    logic clear;    // partial clear
  } fifoStrobe_t;
endpackage

// File: rtl/sfifo_datapath.sv
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned LOW_DEF  = 2,
  parameter int unsigned HIGH_DEF = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrobe_t                strobe,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       serEn,
  input  logic                       serBit,
  output logic [$clog2(DEPTH):0]     lowOff,
  output logic [$clog2(DEPTH):0]     highOff,
  output logic [DATA_W-1:0]          rdData
);
  localparam int unsigned ADDR_W  = $clog2(DEPTH);
  localparam int unsigned CNT_W   = ADDR_W + 1;
  localparam int unsigned CHAIN_W = 2 * CNT_W;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [CHAIN_W-1:0] offChain;
  logic               readHigh;

  assign lowOff  = offChain[CNT_W-1:0];
  assign highOff = offChain[CHAIN_W-1:CNT_W];

  // Storage array, no reset
  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  // Offset chain: new bit enters at the top, so the first bit ends at bit 0
  always_ff @(posedge clk) begin
    if (!rstN)      offChain <= {CNT_W'(HIGH_DEF), CNT_W'(LOW_DEF)};
    else if (serEn) offChain <= {serBit, offChain[CHAIN_W-1:1]};
  end

  // Output register and readback alternation
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      rdData   <= '0;
      readHigh <= 1'b0;
    end else if (strobe.pop) begin
      rdData <= mem[rdAddr];
    end else if (strobe.offRead) begin
      rdData   <= readHigh ? DATA_W'(highOff) : DATA_W'(lowOff);
      readHigh <= ~readHigh;
    end
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clearIn,
  input  logic                       flagModeIn,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic                       loadSel,
  input  logic                       markIn,
  input  logic                       rewindIn,
  input  logic [$clog2(DEPTH):0]     lowOff,
  input  logic [$clog2(DEPTH):0]     highOff,
  output fifoStrobe_t                strobe,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       isEmpty,
  output logic                       isFull,
  output logic                       aboveLowMark,
  output logic                       belowHighMark
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W  = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] wrPtr, rdPtr, markPtr, rewindTgt;
  logic              markValid;
  logic [CNT_W-1:0]  count, freeCnt;
  logic              flagSync, lowReg, highReg, lowNow, highNow;
  logic              idleCmd;

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

  always_comb begin
    isEmpty        = (count == '0);
    isFull         = (count == FULL_CNT);
    idleCmd        = !clearIn && !rewindIn;
    strobe.clear   = clearIn;
    strobe.pop     = idleCmd && rdEn && loadSel && !isEmpty;
    strobe.offRead = idleCmd && rdEn && !loadSel;
    strobe.push    = idleCmd && wrEn && (!isFull || strobe.pop);
    rewindTgt      = markValid ? markPtr : '0;
    freeCnt        = FULL_CNT - count;
    lowNow         = (count >= lowOff);
    highNow        = (freeCnt > highOff);
  end

  // Pointers, occupancy and mark
  always_ff @(posedge clk) begin
    if (!rstN || clearIn) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      markPtr   <= '0;
      markValid <= 1'b0;
    end else if (rewindIn) begin
      rdPtr <= rewindTgt;
      count <= {1'b0, wrPtr - rewindTgt};
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      if (strobe.push && !strobe.pop)      count <= count + 1'b1;
      else if (strobe.pop && !strobe.push) count <= count - 1'b1;
      if (markIn) begin
        markPtr   <= rdPtr;
        markValid <= 1'b1;
      end
    end
  end

  // Flag timing mode and registered flag copies
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagSync <= flagModeIn;
      lowReg   <= 1'b0;
      highReg  <= 1'b1;
    end else begin
      lowReg  <= lowNow;
      highReg <= highNow;
    end
  end

  assign aboveLowMark  = flagSync ? lowReg  : lowNow;
  assign belowHighMark = flagSync ? highReg : highNow;
endmodule

// File: rtl/sync_fifo_pflags.sv
module sync_fifo_pflags
  import sfifo_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned LOW_DEF  = 2,
  parameter int unsigned HIGH_DEF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearIn,
  input  logic              flagModeIn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              loadSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              serEn,
  input  logic              serBit,
  input  logic              markIn,
  input  logic              rewindIn,
  output logic              isEmpty,
  output logic              isFull,
  output logic              aboveLowMark,
  output logic              belowHighMark
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W  = ADDR_W + 1;

  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [CNT_W-1:0]  lowOff, highOff;

  sfifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .flagModeIn(flagModeIn),
    .wrEn(wrEn), .rdEn(rdEn), .loadSel(loadSel), .markIn(markIn),
    .rewindIn(rewindIn), .lowOff(lowOff), .highOff(highOff),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .isEmpty(isEmpty), .isFull(isFull),
    .aboveLowMark(aboveLowMark), .belowHighMark(belowHighMark)
  );

  sfifo_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LOW_DEF(LOW_DEF), .HIGH_DEF(HIGH_DEF)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .serEn(serEn), .serBit(serBit),
    .lowOff(lowOff), .highOff(highOff), .rdData(rdData)
  );
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearIn,
  input logic              rewindIn,
  input logic              wrEn,
  input logic              rdEn,
  input logic              loadSel,
  input logic [DATA_W-1:0] rdData,
  input logic              isEmpty,
  input logic              isFull
);
  // R5: status flags are exclusive
  a_r5_not_both: assert property (@(posedge clk) disable iff (!rstN)
    !(isEmpty && isFull));

  // R3: write into a full buffer without a read keeps it full
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && wrEn && !(rdEn && loadSel) && !clearIn && !rewindIn) |=> isFull);

  // R3: read from an empty buffer without a write changes nothing
  a_r3_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && rdEn && loadSel && !wrEn && !clearIn && !rewindIn)
      |=> (isEmpty && $stable(rdData)));

  // R4: read plus write while full stays full
  a_r4_full_rw: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && wrEn && rdEn && loadSel && !clearIn && !rewindIn) |=> isFull);

  // R10: partial clear empties the buffer and zeroes the output
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (isEmpty && !isFull && rdData == '0));
endmodule

bind sync_fifo_pflags sfifo_checker #(.DATA_W(DATA_W)) i_checker (
  .clk(clk), .rstN(rstN), .clearIn(clearIn), .rewindIn(rewindIn),
  .wrEn(wrEn), .rdEn(rdEn), .loadSel(loadSel), .rdData(rdData),
  .isEmpty(isEmpty), .isFull(isFull)
);

// File: tb/test_sync_fifo_pflags.sv
`timescale 1ns/1ps
module test_sync_fifo_pflags;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int CW    = 4;
  localparam int CHW   = 2 * CW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0, clearIn = 1'b0, flagModeIn = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0, loadSel = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic          serEn = 1'b0, serBit = 1'b0, markIn = 1'b0, rewindIn = 1'b0;
  logic [DW-1:0] rdData;
  logic          isEmpty, isFull, aboveLowMark, belowHighMark;

  sync_fifo_pflags #(.DATA_W(DW), .DEPTH(DEPTH), .LOW_DEF(2), .HIGH_DEF(2)) i_sync_fifo_pflags (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .flagModeIn(flagModeIn),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .loadSel(loadSel), .rdData(rdData),
    .serEn(serEn), .serBit(serBit), .markIn(markIn), .rewindIn(rewindIn),
    .isEmpty(isEmpty), .isFull(isFull),
    .aboveLowMark(aboveLowMark), .belowHighMark(belowHighMark)
  );

  int checks = 0, errors = 0;
  string curTag = "R1";

  // Reference model state
  logic [DW-1:0]  mMem [DEPTH];
  int             mWr, mRd, mCnt, mMark;
  bit             mMarkV, mSync, mTog, sLow, sHigh;
  logic [CHW-1:0] mChain;
  logic [DW-1:0]  mData;

  function automatic bit lowCmp(int cnt, logic [CHW-1:0] ch);
    return cnt >= int'(ch[CW-1:0]);
  endfunction
  function automatic bit highCmp(int cnt, logic [CHW-1:0] ch);
    return (DEPTH - cnt) > int'(ch[CHW-1:CW]);
  endfunction

  task automatic modelEdge();
    bit pLow, pHigh, pop, push;
    int tgt, oldRd;
    pLow  = lowCmp(mCnt, mChain);
    pHigh = highCmp(mCnt, mChain);
    if (!rstN) begin
      mWr = 0; mRd = 0; mCnt = 0; mMarkV = 0; mMark = 0; mTog = 0;
      mData = '0; mSync = flagModeIn; sLow = 0; sHigh = 1;
      mChain = {4'd2, 4'd2};
    end else begin
      if (clearIn) begin
        mWr = 0; mRd = 0; mCnt = 0; mMarkV = 0; mData = '0; mTog = 0;
      end else if (rewindIn) begin
        tgt  = mMarkV ? mMark : 0;
        mRd  = tgt;
        mCnt = (mWr - tgt + DEPTH) % DEPTH;
      end else begin
        oldRd = mRd;
        pop  = rdEn && loadSel && (mCnt != 0);
        push = wrEn && ((mCnt != DEPTH) || pop);
        if (pop) begin
          mData = mMem[mRd];
          mRd = (mRd + 1) % DEPTH;
        end else if (rdEn && !loadSel) begin
          mData = mTog ? DW'(mChain[CHW-1:CW]) : DW'(mChain[CW-1:0]);
          mTog = !mTog;
        end
        if (push) begin
          mMem[mWr] = wrData;
          mWr = (mWr + 1) % DEPTH;
        end
        if (push && !pop) mCnt++;
        else if (pop && !push) mCnt--;
        if (markIn) begin mMark = oldRd; mMarkV = 1; end
      end
      sLow = pLow; sHigh = pHigh;
      if (serEn) mChain = {serBit, mChain[CHW-1:1]};
    end
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("isEmpty (R5)", 32'(isEmpty), 32'(mCnt == 0));
    chk("isFull (R5)",  32'(isFull),  32'(mCnt == DEPTH));
    chk("rdData (R2)",  32'(rdData),  32'(mData));
    chk("aboveLowMark (R6)",  32'(aboveLowMark),  32'(mSync ? sLow  : lowCmp(mCnt, mChain)));
    chk("belowHighMark (R7)", 32'(belowHighMark), 32'(mSync ? sHigh : highCmp(mCnt, mChain)));
  endtask

  // one clock: inputs already set at negedge, model at the edge, compare after
  task automatic tick();
    @(posedge clk);
    modelEdge();
    #1;
    compareAll();
    @(negedge clk);
  endtask

  task automatic idle();
    rstN = 1; clearIn = 0; wrEn = 0; rdEn = 0; loadSel = 1;
    serEn = 0; markIn = 0; rewindIn = 0;
  endtask

  task automatic doWrite(logic [DW-1:0] d);
    idle(); wrEn = 1; wrData = d; tick(); idle();
  endtask
  task automatic doRead();
    idle(); rdEn = 1; tick(); idle();
  endtask

  task automatic loadOffsets(logic [CW-1:0] lo, logic [CW-1:0] hi);
    logic [CHW-1:0] v;
    v = {hi, lo};
    for (int i = 0; i < CHW; i++) begin
      idle(); serEn = 1; serBit = v[i]; tick();
    end
    idle();
  endtask

  task automatic masterReset(bit mode);
    idle(); rstN = 0; flagModeIn = mode; tick(); tick(); idle(); flagModeIn = 0;
  endtask

  task automatic randomRun(int n);
    for (int i = 0; i < n; i++) begin
      idle();
      wrEn     = ($urandom % 2) == 0;
      rdEn     = ($urandom % 2) == 0;
      loadSel  = ($urandom % 10) != 0;
      wrData   = DW'($urandom);
      clearIn  = ($urandom % 100) == 0;
      rewindIn = ($urandom % 40) == 0;
      markIn   = ($urandom % 30) == 0;
      serEn    = ($urandom % 12) == 0;
      serBit   = ($urandom % 2) == 0;
      tick();
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R1 reset state with R13 immediate flag mode
    curTag = "R1"; masterReset(1'b0);
    chk("reset empty", 32'(isEmpty), 1); chk("reset data", 32'(rdData), 0);

    // R2 order, R3 overflow, R5 full
    curTag = "R2";
    for (int i = 0; i < DEPTH; i++) doWrite(DW'(8'h10 + i));
    curTag = "R3"; doWrite(8'hEE);
    curTag = "R4"; idle(); wrEn = 1; wrData = 8'h77; rdEn = 1; tick(); idle();
    chk("R4 full kept", 32'(isFull), 1);
    curTag = "R2";
    for (int i = 0; i < DEPTH; i++) doRead();
    chk("R4 last word", 32'(rdData), 32'h77);
    curTag = "R3"; doRead();
    chk("R3 empty read holds", 32'(rdData), 32'h77);

    // R8 serial load, R9 readback
    curTag = "R8"; loadOffsets(4'd3, 4'd5);
    curTag = "R9"; idle(); rdEn = 1; loadSel = 0; tick();
    chk("R9 low offset", 32'(rdData), 3);
    tick(); chk("R9 high offset", 32'(rdData), 5); idle();

    // R11 mark, R12 rewind
    curTag = "R11";
    for (int i = 0; i < 5; i++) doWrite(DW'(8'hA0 + i));
    doRead(); doRead();
    idle(); markIn = 1; tick(); idle();
    doRead(); doRead();
    curTag = "R12"; idle(); rewindIn = 1; wrEn = 1; rdEn = 1; tick(); idle();
    doRead(); chk("R12 replay from mark", 32'(rdData), 32'hA2);

    // R10 partial clear keeps offsets
    curTag = "R10"; idle(); clearIn = 1; wrEn = 1; rdEn = 1; tick(); idle();
    idle(); rdEn = 1; loadSel = 0; tick(); idle();
    chk("R10 offset kept", 32'(rdData), 3);
    curTag = "R12"; idle(); rewindIn = 1; tick(); idle();

    curTag = "R2 random"; randomRun(1500);

    // R13 registered flag mode
    curTag = "R13"; masterReset(1'b1);
    loadOffsets(4'd2, 4'd3);
    for (int i = 0; i < 6; i++) doWrite(DW'(i));
    curTag = "R13 random"; randomRun(1500);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule